// File: doc/BRIEF.md
# Masked Pattern-Match Trigger Detector

This block watches a 32-bit data word and raises a one-cycle event when the word satisfies a programmed condition. The condition is one of three: the examined bits equal a stored pattern, the examined bits differ from that pattern, or any examined bit changed since the previous sample. A mask picks the examined bits. The data can be judged on every clock from the live lines, or only on the words that a sample strobe captures.

Each detection leaves through one of three outputs, chosen by a role field: begin acquisition, end acquisition, or raise a message. Software writes the configuration while the detector is idle and then pulses `arm`. Pulsing `arm` again restarts the detector from a clean baseline, and `disarm` returns it to idle. Data and strobe pass through a two-stage synchroniser before they reach the comparator.

The controller has four states:
- IDLE: not watching, and configuration writes are accepted. `arm` moves to PRIME.
- PRIME: the first sample loads the change baseline without firing, then the controller moves to SEEK.
- SEEK: a satisfied sample fires an event. In live pattern mode the controller then moves to HELD; in the other modes it stays in SEEK.
- HELD: waits for the condition to fail, then returns to SEEK.

From any armed state, `disarm` returns the controller to IDLE and a repeated `arm` returns it to PRIME.

Top module: `pattern_trigger_detector`

## Requirements
- R1: After reset all three event outputs are 0, `armed` is 0, and the pattern, mask and mode settings are all zero.
- R2: In pattern mode only bits with a 1 in the mask take part in the comparison. A mask of 0 makes every sample count as equal to the pattern.
- R3: With `cfg_on_mismatch`=1 an event fires when the examined bits differ from the pattern. With 0 it fires when they are equal.
- R4: In live mode (`cfg_strobed`=0, `cfg_change`=0) every clock is a sample, and a held condition gives exactly one pulse. A further pulse needs the condition to go false and then true again.
- R5: With `cfg_strobed`=1 only cycles with `strobe` high are samples. Every strobed sample that satisfies the condition gives a pulse, and no pulse arises without a strobe.
- R6: With `cfg_change`=1 an event fires on each sample in which any masked-in bit differs from the previous sample. Changes on masked-out bits fire nothing.
- R7: `cfg_role` routes events: 0 drives `start_evt`, 1 drives `stop_evt`, and 2 or 3 drive `msg_evt`. At most one event output is high in any cycle.
- R8: A data word or strobe applied before clock edge k produces its event as an output that is high after edge k+2: two synchroniser stages plus the output register.
- R9: `cfg_we` loads the configuration only while the detector is idle. A write while it is armed changes nothing.
- R10: `arm` enters PRIME, and the first sample after arming only sets the baseline without firing. `disarm`, or an `arm` pulse in the same cycle, suppresses any event. While idle no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 32 | Data word (asynchronous to clk) |
| strobe | input | 1 | Sample strobe for strobed mode |
| cfg_we | input | 1 | Configuration write enable |
| cfg_pattern | input | 32 | Pattern to compare against |
| cfg_mask | input | 32 | 1 = bit is examined |
| cfg_on_mismatch | input | 1 | 1 = fire on mismatch, 0 = fire on match |
| cfg_strobed | input | 1 | 1 = judge strobed samples only |
| cfg_change | input | 1 | 1 = change detection instead of pattern |
| cfg_role | input | 2 | Event routing: 0 start, 1 stop, 2/3 message |
| arm | input | 1 | Arm or re-arm the detector |
| disarm | input | 1 | Return to idle |
| armed | output | 1 | Detector is not idle |
| start_evt | output | 1 | One-cycle start-trigger event |
| stop_evt | output | 1 | One-cycle stop-trigger event |
| msg_evt | output | 1 | One-cycle message event |

## Verification
An event is due three clock edges after the data or strobe that causes it is applied. An `arm` pulse takes effect on the next edge, and PRIME takes one more sample before the first event can fire. The bench drives every input just after a falling edge and reads outputs only at falling edges, so each value is read half a period after the edge that set it. A directed case counts the edges exactly: the output is 0 after the second edge, 1 after the third and 0 after the fourth. A cycle-level expectation model in the bench applies the same three-edge delay to the randomised episodes, so every cycle's outputs are compared at the cycle in which they are due.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_SEEK  = 2'd2,
        ST_HELD  = 2'd3
    } det_state_e;

    typedef enum logic [1:0] {
        ROLE_START   = 2'd0,
        ROLE_STOP    = 2'd1,
        ROLE_MSG     = 2'd2,
        ROLE_MSG_ALT = 2'd3
    } role_e;
endpackage

// File: rtl/ptd_sync.sv
module ptd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ptd_compare.sv
module ptd_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] baseline,
    input  logic         on_mismatch,
    input  logic         change_mode,
    output logic         cond
);
    logic [W-1:0] diff_pat;
    logic [W-1:0] diff_base;
    logic         equal_pat;
    logic         moved;

    always_comb begin
        diff_pat  = (sample ^ pattern) & mask;
        diff_base = (sample ^ baseline) & mask;
        equal_pat = (diff_pat == '0);
        moved     = (diff_base != '0);
        cond      = change_mode ? moved : (equal_pat ^ on_mismatch);
    end
endmodule

// File: rtl/pattern_trigger_detector.sv
module pattern_trigger_detector
    import ptd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              strobe,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_pattern,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic              cfg_on_mismatch,
    input  logic              cfg_strobed,
    input  logic              cfg_change,
    input  logic [1:0]        cfg_role,
    input  logic              arm,
    input  logic              disarm,
    output logic              armed,
    output logic              start_evt,
    output logic              stop_evt,
    output logic              msg_evt
);
    localparam int SYNC_W = DATA_W + 1;

    det_state_e        state_q, state_d;
    logic [DATA_W-1:0] pat_q, mask_q, base_q, smp;
    logic              mism_q, strobed_q, change_q;
    role_e             role_q;
    logic              stb_s, sample_now, cond, fire;
    logic [SYNC_W-1:0] sync_out;

    ptd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({strobe, data_in}),
        .q    (sync_out)
    );
    assign smp   = sync_out[DATA_W-1:0];
    assign stb_s = sync_out[DATA_W];

    ptd_compare #(.W(DATA_W)) u_cmp (
        .sample     (smp),
        .pattern    (pat_q),
        .mask       (mask_q),
        .baseline   (base_q),
        .on_mismatch(mism_q),
        .change_mode(change_q),
        .cond       (cond)
    );

    assign sample_now = strobed_q ? stb_s : 1'b1;
    assign armed      = (state_q != ST_IDLE);

    // configuration: accepted only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q     <= '0;
            mask_q    <= '0;
            mism_q    <= 1'b0;
            strobed_q <= 1'b0;
            change_q  <= 1'b0;
            role_q    <= ROLE_START;
        end else if (cfg_we && state_q == ST_IDLE) begin
            pat_q     <= cfg_pattern;
            mask_q    <= cfg_mask;
            mism_q    <= cfg_on_mismatch;
            strobed_q <= cfg_strobed;
            change_q  <= cfg_change;
            role_q    <= role_e'(cfg_role);
        end
    end

    // change-detection baseline follows every armed sample
    always_ff @(posedge clk) begin
        if (!rst_n)                                base_q <= '0;
        else if (state_q != ST_IDLE && sample_now) base_q <= smp;
    end

    always_comb begin
        fire    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_PRIME;
            ST_PRIME: if (sample_now) state_d = ST_SEEK;
            ST_SEEK: begin
                if (sample_now && cond) begin
                    fire = 1'b1;
                    if (!strobed_q && !change_q) state_d = ST_HELD;
                end
            end
            ST_HELD:  if (!cond) state_d = ST_SEEK;
        endcase
        if (state_q != ST_IDLE) begin
            if (disarm) begin
                state_d = ST_IDLE;
                fire    = 1'b0;
            end else if (arm) begin
                state_d = ST_PRIME;
                fire    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_evt <= 1'b0;
            stop_evt  <= 1'b0;
            msg_evt   <= 1'b0;
        end else begin
            start_evt <= fire && (role_q == ROLE_START);
            stop_evt  <= fire && (role_q == ROLE_STOP);
            msg_evt   <= fire && (role_q == ROLE_MSG || role_q == ROLE_MSG_ALT);
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_evt, stop_evt, msg_evt}) <= 1); // R7
    AST_LIVE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_evt || stop_evt || msg_evt) && !strobed_q && !change_q)
        |=> !(start_evt || stop_evt || msg_evt)); // R4
    AST_STROBE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed_q && !stb_s) |=> !(start_evt || stop_evt || msg_evt)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(pat_q) && $stable(mask_q) && $stable(role_q))); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !(start_evt || stop_evt || msg_evt)); // R10
    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> !(start_evt || stop_evt || msg_evt)); // R10
endmodule

// File: tb/pattern_trigger_detector_tb.sv
`timescale 1ns/1ps
module pattern_trigger_detector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic        strobe = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_pattern = '0;
    logic [31:0] cfg_mask = '0;
    logic        cfg_on_mismatch = 1'b0;
    logic        cfg_strobed = 1'b0;
    logic        cfg_change = 1'b0;
    logic [1:0]  cfg_role = '0;
    logic        arm = 1'b0;
    logic        disarm = 1'b0;
    logic        armed, start_evt, stop_evt, msg_evt;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pattern_trigger_detector u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe(strobe),
        .cfg_we(cfg_we), .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask),
        .cfg_on_mismatch(cfg_on_mismatch), .cfg_strobed(cfg_strobed),
        .cfg_change(cfg_change), .cfg_role(cfg_role), .arm(arm), .disarm(disarm),
        .armed(armed), .start_evt(start_evt), .stop_evt(stop_evt), .msg_evt(msg_evt)
    );

    // expectation model built from the requirements
    logic [31:0] m_d1, m_d2, m_pat, m_msk, m_base;
    logic        m_s1, m_s2, m_mis, m_stb, m_chg;
    logic [1:0]  m_role;
    int          m_st;
    logic        m_start, m_stop, m_msg;

    function automatic bit hit(input logic [31:0] s);
        if (m_chg) return ((s ^ m_base) & m_msk) != 0;
        return ((((s ^ m_pat) & m_msk) == 0) ? 1'b1 : 1'b0) ^ m_mis;
    endfunction

    always @(posedge clk) begin
        bit smp, f;
        int nst;
        if (!rst_n) begin
            m_d1 <= '0; m_d2 <= '0; m_s1 <= 0; m_s2 <= 0;
            m_pat <= '0; m_msk <= '0; m_base <= '0;
            m_mis <= 0; m_stb <= 0; m_chg <= 0; m_role <= 0; m_st <= 0;
            m_start <= 0; m_stop <= 0; m_msg <= 0;
        end else begin
            smp = m_stb ? m_s2 : 1'b1;
            f = 0;
            nst = m_st;
            if (m_st == 0 && arm) nst = 1;
            else if (m_st == 1 && smp) nst = 2;
            else if (m_st == 2 && smp && hit(m_d2)) begin
                f = 1;
                if (!m_stb && !m_chg) nst = 3;
            end else if (m_st == 3 && !hit(m_d2)) nst = 2;
            if (m_st != 0 && disarm) begin nst = 0; f = 0; end
            else if (m_st != 0 && arm) begin nst = 1; f = 0; end
            if (m_st != 0 && smp) m_base <= m_d2;
            if (cfg_we && m_st == 0) begin
                m_pat <= cfg_pattern; m_msk <= cfg_mask; m_mis <= cfg_on_mismatch;
                m_stb <= cfg_strobed; m_chg <= cfg_change; m_role <= cfg_role;
            end
            m_start <= f && m_role == 2'd0;
            m_stop  <= f && m_role == 2'd1;
            m_msg   <= f && m_role[1];
            m_st <= nst;
            m_d1 <= data_in; m_d2 <= m_d1; m_s1 <= strobe; m_s2 <= m_s1;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            string t;
            t = m_chg ? "R6 change" : (m_stb ? "R5 strobed" : "R4 live");
            check(start_evt, m_start, {t, " R7 start_evt"});
            check(stop_evt,  m_stop,  {t, " R7 stop_evt"});
            check(msg_evt,   m_msg,   {t, " R7 msg_evt"});
            check(armed, m_st != 0, "R10 armed");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] p, input logic [31:0] m, input logic mis,
                             input logic stb, input logic chg, input logic [1:0] role);
        cfg_pattern = p; cfg_mask = m; cfg_on_mismatch = mis;
        cfg_strobed = stb; cfg_change = chg; cfg_role = role; cfg_we = 1;
        cyc(1);
        cfg_we = 0;
    endtask

    task automatic pulse_arm();
        arm = 1; cyc(1); arm = 0;
    endtask

    task automatic pulse_disarm();
        disarm = 1; cyc(1); disarm = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check(armed, 1'b0, "R1 armed");
        check(start_evt | stop_evt | msg_evt, 1'b0, "R1 events");
        model_on = 1;

        // R8 latency, R2 mask, R4 single pulse
        write_cfg(32'hA5A5_0F0F, 32'hFFFF_00FF, 0, 0, 0, 2'd0);
        data_in = 32'h0;
        pulse_arm();
        cyc(3);
        data_in = 32'hA5A5_770F;          // differs only in masked-out bits
        cyc(2);
        check(start_evt, 1'b0, "R8 not yet after two edges");
        cyc(1);
        check(start_evt, 1'b1, "R8 R2 event after third edge");
        cyc(1);
        check(start_evt, 1'b0, "R4 single pulse");
        cyc(5);
        check(start_evt, 1'b0, "R4 no refire while held");
        data_in = 32'h0; cyc(2);
        data_in = 32'hA5A5_0F0F; cyc(3);
        check(start_evt, 1'b1, "R4 refire after false");

        // R9 write while armed is ignored
        write_cfg(32'h1234_5678, 32'hFFFF_FFFF, 0, 0, 0, 2'd1);
        data_in = 32'h0; cyc(3);
        data_in = 32'h1234_5678; cyc(4);
        check(stop_evt, 1'b0, "R9 new role not applied");
        check(start_evt, 1'b0, "R9 new pattern not matched");
        pulse_disarm();

        // R3 mismatch + R5 strobed, role stop
        write_cfg(32'hFFFF_0000, 32'hFFFF_FFFF, 1, 1, 0, 2'd1);
        data_in = 32'hFFFF_0000;
        pulse_arm();
        strobe = 1; cyc(1); strobe = 0; cyc(4);   // priming sample
        data_in = 32'h0000_0001; cyc(4);
        check(stop_evt, 1'b0, "R5 no event without strobe");
        strobe = 1; cyc(1); strobe = 0; cyc(1);
        check(stop_evt, 1'b0, "R8 strobed not yet");
        cyc(1);
        check(stop_evt, 1'b1, "R3 R5 mismatch on strobe");
        pulse_disarm();

        // R6 change detect, message role, R10 prime is silent
        write_cfg(32'h0, 32'h0000_FFFF, 0, 0, 1, 2'd3);
        data_in = 32'h0000_0000;
        pulse_arm();
        cyc(4);
        data_in = 32'hFFFF_0000; cyc(4);
        check(msg_evt, 1'b0, "R6 masked change ignored");
        data_in = 32'hFFFF_0010; cyc(3);
        check(msg_evt, 1'b1, "R6 R7 change fires message");
        pulse_disarm();
        data_in = 32'h0; cyc(4);
        check(msg_evt, 1'b0, "R10 idle silent");

        // randomised episodes
        for (int ep = 0; ep < 60; ep++) begin
            logic [31:0] p, m;
            logic chg;
            p = $urandom;
            m = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            chg = ($urandom % 4 == 0);
            pulse_disarm();
            write_cfg(p, m, $urandom % 2, $urandom % 2, chg, $urandom % 4);
            pulse_arm();
            for (int k = 0; k < 120; k++) begin
                int r;
                r = $urandom % 16;
                if (chg) begin
                    if (r < 4) data_in = data_in ^ (32'h1 << ($urandom % 32));
                end else if (r < 7) data_in = p ^ ($urandom & ~m);
                else if (r < 10) data_in = $urandom;
                strobe = ($urandom % 3 == 0);
                cfg_we = ($urandom % 20 == 0);
                cfg_pattern = $urandom;
                cfg_role = $urandom % 4;
                arm = ($urandom % 50 == 0);
                disarm = ($urandom % 90 == 0);
                cyc(1);
                cfg_we = 0; arm = 0; disarm = 0;
            end
            strobe = 0;
        end
        cyc(4);
        finish_run();
    end
endmodule